// File: doc/BRIEF.md
# Low-Frequency Periodic Interrupt Timer

This block raises a periodic interrupt request from a slow reference tick, typically a 32.768 kHz crystal clock that has already been turned into a one-cycle enable pulse in the system clock domain. A single control register holds a run flag and a three-bit interval code. While the run flag is set, a binary counter advances once per slow tick. Each time the counter completes the chosen power-of-two interval, the block pulses its interrupt output for one system clock cycle. The counter then keeps counting.

The interval code is protected while the timer runs. A write that starts the timer may load a new code in the same access. A write made while the timer is running leaves the code unchanged, and this includes the write that stops the timer. Stopping the timer clears the counter, so the next start always measures a full interval from zero. Software reads back the run flag and the code that is actually in force.

Top module: `rtc_interval_timer`

## Requirements
- R1: A synchronous reset clears the run flag, the interval code and the counter, and `irq` stays low during reset and in the cycle after it.
- R2: A write with the run bit (`wrData[SEL_W]`) set while stopped starts counting, and the counter advances only in cycles where `tickEn` is high.
- R3: With interval code k in force, `irq` is high for exactly one system cycle, in the cycle right after the tick that brings the total tick count since start to a multiple of 2^(CNT_W-k) (default CNT_W=15: code 0 gives 32768 ticks and code 7 gives 256 ticks).
- R4: The counter keeps running after each interrupt, so a further `irq` follows every 2^(CNT_W-k) ticks.
- R5: A write made while running does not change the interval code (`wrData[SEL_W-1:0]`), and the code already in force keeps setting the period.
- R6: A write with the run bit clear, made while running, stops the timer and clears the counter. The interval code is kept, and no further `irq` occurs while stopped, even if ticks arrive.
- R7: Writing the run bit as 1 while already running does not reset or disturb the counter, so the interrupt timing carries on unchanged.
- R8: `rdData` returns the run flag in bit SEL_W and the interval code in force in bits SEL_W-1:0, not the last value written.
- R9: A write with the run bit clear, made while stopped, loads the interval code without starting the counter.
- R10: When a stop write falls in the same cycle as the tick that would complete an interval, no `irq` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | One-cycle pulse for each slow-clock tick |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | SEL_W+1 | Write value: bit SEL_W is run, the low bits are the interval code |
| rdData | output | SEL_W+1 | Current run flag and the interval code in force |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench uses a 10-bit counter and starts the timer once with every interval code. Each code is run with ticks on back-to-back cycles and again with two idle cycles between ticks. The first case shows that the period is counted in ticks and not in cycles. The second shows that `irq` follows the tick and does not hold over the idle cycles. In the middle of each run the bench writes a different code with the run bit set. The phase of the later interrupts shows whether the lock held and whether the counter was left undisturbed. Each run then ends with a stop write that carries yet another code. Further cases cover a code loaded while stopped, ticks arriving while stopped, and a stop that falls on the tick that would complete an interval.

// File: rtl/rtc_timer_pkg.sv
package rtc_timer_pkg;

  // Strobes from the control path to the counter datapath.
  typedef struct packed {
    logic clearCnt;  // force the counter to zero
    logic advance;   // count one slow tick
  } dpStrobe_t;

endpackage

// File: rtl/rtc_timer_ctrl.sv
module rtc_timer_ctrl
  import rtc_timer_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic             wrRun,
  input  logic [SEL_W-1:0] wrSel,
  output logic             runState,
  output logic [SEL_W-1:0] selState,
  output dpStrobe_t        strobe
);

  logic stopping;

  // The code may change only while stopped: a start write loads it,
  // and any write made while running leaves it alone.
  always_ff @(posedge clk) begin
    if (rst) begin
      runState <= 1'b0;
      selState <= '0;
    end else if (wrEn) begin
      runState <= wrRun;
      if (!runState) begin
        selState <= wrSel;
      end
    end
  end

  always_comb begin
    stopping        = wrEn && !wrRun && runState;
    strobe.clearCnt = !runState || stopping;
    strobe.advance  = runState && tickEn && !stopping;
  end

endmodule

// File: rtl/rtc_timer_datapath.sv
module rtc_timer_datapath
  import rtc_timer_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  input  logic [SEL_W-1:0] selState,
  output logic [CNT_W-1:0] countVal,
  output logic             irq
);

  logic lowOnes;
  int   topBit;

  // The selected bit falls from 1 to 0 on the tick that follows the
  // state where it and every bit below it are 1.
  always_comb begin
    topBit  = CNT_W - 1 - int'(selState);
    lowOnes = 1'b1;
    for (int i = 0; i < CNT_W; i++) begin
      if (i <= topBit) begin
        lowOnes = lowOnes && countVal[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clearCnt) begin
      countVal <= '0;
    end else if (strobe.advance) begin
      countVal <= countVal + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= strobe.advance && lowOnes;
    end
  end

endmodule

// File: rtl/rtc_interval_timer.sv
module rtc_interval_timer
  import rtc_timer_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [SEL_W:0]   wrData,
  output logic [SEL_W:0]   rdData,
  output logic             irq
);

  localparam int RUN_BIT = SEL_W;

  dpStrobe_t        strobe;
  logic             runState;
  logic [SEL_W-1:0] selState;
  logic [CNT_W-1:0] countVal;

  rtc_timer_ctrl #(.SEL_W(SEL_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .tickEn   (tickEn),
    .wrEn     (wrEn),
    .wrRun    (wrData[RUN_BIT]),
    .wrSel    (wrData[SEL_W-1:0]),
    .runState (runState),
    .selState (selState),
    .strobe   (strobe)
  );

  rtc_timer_datapath #(.CNT_W(CNT_W), .SEL_W(SEL_W)) uDp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .selState (selState),
    .countVal (countVal),
    .irq      (irq)
  );

  assign rdData = {runState, selState};

endmodule

// File: rtl/rtc_interval_timer_chk.sv
module rtc_interval_timer_chk #(
  parameter int CNT_W = 15,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             tickEn,
  input logic             wrEn,
  input logic [SEL_W:0]   wrData,
  input logic [SEL_W:0]   rdData,
  input logic             irq,
  input logic [CNT_W-1:0] cntMon
);

  logic rstQ;
  always_ff @(posedge clk) rstQ <= rst;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (rdData == '0 && !irq)); // R1

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rdData[SEL_W] && !tickEn && !wrEn && !rstQ) |=> $stable(cntMon)); // R2

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R3

  AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    (irq && !rstQ) |-> ($past(tickEn) && $past(rdData[SEL_W]))); // R3

  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (!rstQ && $past(rdData[SEL_W])) |-> (rdData[SEL_W-1:0] == $past(rdData[SEL_W-1:0]))); // R5

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrData[SEL_W]) |=> (cntMon == '0 && !rdData[SEL_W])); // R6

  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    !rdData[SEL_W] |=> !irq); // R9

  AST_STOP_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrData[SEL_W]) |=> !irq); // R10

endmodule

bind rtc_interval_timer rtc_interval_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) uChk (
  .clk    (clk),
  .rst    (rst),
  .tickEn (tickEn),
  .wrEn   (wrEn),
  .wrData (wrData),
  .rdData (rdData),
  .irq    (irq),
  .cntMon (countVal)
);

// File: tb/tb_rtc_interval_timer.sv
module tb_rtc_interval_timer;

  localparam int CW = 10;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tickEn = 1'b0;
  logic          wrEn = 1'b0;
  logic [SW:0]   wrData = '0;
  logic [SW:0]   rdData;
  logic          irq;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  rtc_interval_timer #(.CNT_W(CW), .SEL_W(SW)) dut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive inputs for one cycle, then sample just after the rising edge.
  task automatic cyc(input logic t, input logic w, input logic [SW:0] d);
    @(negedge clk);
    tickEn = t; wrEn = w; wrData = d;
    @(posedge clk);
    #1;
    tickEn = 1'b0; wrEn = 1'b0; wrData = '0;
  endtask

  task automatic runCode(input int s, input int gap);
    logic [SW-1:0] sv;
    int iv;
    int tk;
    int nIrq;
    sv = SW'(s);
    iv = 1 << (CW - s);
    tk = 0;
    nIrq = 0;
    cyc(1'b0, 1'b1, {1'b1, sv});
    check("R2/R8 start readback", rdData, {1'b1, sv});
    for (int n = 1; n <= 2 * iv + 3; n++) begin
      cyc(1'b1, 1'b0, '0);
      tk++;
      check("R3/R4 irq on tick", irq, (tk % iv) == 0);
      if (irq) nIrq++;
      if (n == iv / 2) begin
        cyc(1'b0, 1'b1, {1'b1, sv ^ 3'd5});
        check("R5 code locked while running", rdData, {1'b1, sv});
        check("R7 rewrite run no irq", irq, 0);
      end
      for (int g = 0; g < gap; g++) begin
        cyc(1'b0, 1'b0, '0);
        check("R2 no irq between ticks", irq, 0);
      end
    end
    check("R4 irq count", nIrq, 2);
    cyc(1'b0, 1'b1, {1'b0, sv ^ 3'd3});
    check("R6 stop keeps code", rdData, {1'b0, sv});
    for (int n = 0; n < 6; n++) begin
      cyc(1'b1, 1'b0, '0);
      check("R6 no irq while stopped", irq, 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset readback", rdData, 0);
    check("R1 reset irq", irq, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 after reset irq", irq, 0);

    // Load a code while stopped: no start, no interrupt.
    cyc(1'b0, 1'b1, {1'b0, 3'd5});
    check("R9 code loaded while stopped", rdData, {1'b0, 3'd5});
    for (int n = 0; n < 40; n++) begin
      cyc(1'b1, 1'b0, '0);
      check("R9 no irq when stopped", irq, 0);
    end

    for (int s = 0; s < 8; s++) begin
      runCode(s, 0);
      runCode(s, 2);
    end

    // A stop that lands on the completing tick suppresses the interrupt.
    cyc(1'b0, 1'b1, {1'b1, 3'd7});
    for (int n = 0; n < 7; n++) begin
      cyc(1'b1, 1'b0, '0);
      check("R10 pre-stop ticks", irq, 0);
    end
    cyc(1'b1, 1'b1, {1'b0, 3'd7});
    check("R10 stop on terminal tick", irq, 0);
    check("R10 stopped readback", rdData, {1'b0, 3'd7});
    cyc(1'b0, 1'b0, '0);
    check("R10 no late irq", irq, 0);

    // Restart after the stop: a full interval is needed again.
    cyc(1'b0, 1'b1, {1'b1, 3'd7});
    for (int n = 1; n <= 8; n++) begin
      cyc(1'b1, 1'b0, '0);
      check("R6 counter cleared by stop", irq, n == 8);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule